// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block is a small timer peripheral with four channels on a 32-bit register bus. Three channels count down: two are 16 bits wide and one is 32 bits wide. Each runs from one of two tick enables, selected per channel. When a down-counter passes zero it raises a pending interrupt. It then either reloads from its load register (periodic mode) or wraps to all ones (free-running mode). The fourth channel is a 40-bit up-counter that runs on the fast tick and has no interrupt. It serves as a timestamp source, and software reads it as a low word and a high word. Tick generation lies outside the block.

Each down-channel is a two-state machine. State CH_HALT holds the count. The transition "start" (a control write with the enable bit set, made while halted) copies the load register into the count and enters CH_COUNT. In CH_COUNT the count steps once per selected tick. The transition "stop" (a control write with the enable bit clear) returns to CH_HALT. The timestamp channel uses the same two states. Here "start" and "stop" are driven by bit 8 of its high register, and leaving CH_COUNT zeroes the count. The usual programming sequence writes the mode with enable clear, then the load value, then the same mode with enable set.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset every count, load value, control field and pending interrupt reads as zero, and `irq` is 3'b000.
- R2: Channels 0 and 1 keep only bits 15:0 of a load write and read back zero above bit 15; channel 2 keeps all 32 bits.
- R3: A control write with bit 7 set to a halted channel copies its load value into the count on that edge; the count then drops by one on each selected tick.
- R4: Control bit 3 selects the tick: 1 counts on `tick_slow`, 0 counts on `tick_fast`; the other tick has no effect on the count.
- R5: With control bit 6 set (periodic), a selected tick at count zero reloads the load value, so a load value of N-1 gives one underflow every N ticks.
- R6: With control bit 6 clear (free-running), a selected tick at count zero wraps the count to all ones of the channel width.
- R7: An underflow sets that channel's pending flag, visible on `irq[c]`, on the same clock edge as the count update.
- R8: Any write to a channel's clear register drops its pending flag on that edge; if an underflow of that channel occurs on the same edge, the flag stays set.
- R9: A control write with bit 7 clear halts the channel; its count holds under ticks, and a later enabling write reloads from the load register.
- R10: Bit 8 of the timestamp high register enables the 40-bit counter, which then adds one per `tick_fast`; writing bit 8 as 0 zeroes and holds it; it drives no interrupt.
- R11: The timestamp low register returns count bits 31:0, and the high register returns bits 39:32 in bits 7:0 with the enable flag in bit 8.
- R12: Register map (byte addresses): down-channel c (0..2) has load at 16c+0, count at 16c+4 (read only), control at 16c+8 and clear at 16c+12; the timestamp low word is at 0x30 and the high word at 0x34. Control reads return enable in bit 7, periodic in bit 6 and tick select in bit 3, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | Slow count enable, one cycle wide |
| tick_fast | input | 1 | Fast count enable, one cycle wide |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 3 | Pending interrupt of each down-channel |

## Verification
Reads have no cycle of latency: `bus_rdata` follows `bus_addr` in the same cycle, so the bench samples it a fraction of a nanosecond after changing the address. Writes, ticks and the pending flags all take effect on the first rising edge after they are driven. The bench therefore drives every stimulus at a falling edge, removes it at the next falling edge, and only then compares counts, control fields and `irq` against its own model. A write applied together with a tick in the same cycle is resolved in the model with the same priority as the requirements: a control write wins over the tick, and an underflow wins over a clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DOWN_CH_N    = 3;
    localparam int BIT_EN       = 7;
    localparam int BIT_PERIODIC = 6;
    localparam int BIT_SLOW     = 3;
    localparam int BIT_STAMP_EN = 8;

    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLEAR = 2'd3
    } reg_sel_t;

    typedef enum logic {
        CH_HALT  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_t;
endpackage

// File: rtl/down_chan.sv
module down_chan
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_slow,
    input  logic        tick_fast,
    input  logic        wr_load,
    input  logic        wr_ctrl,
    input  logic        wr_clear,
    input  logic [31:0] wdata,
    output logic [31:0] rd_count,
    output logic [31:0] rd_load,
    output logic [31:0] rd_ctrl,
    output logic        irq
);
    ch_state_t      state_q, state_d;
    logic [W-1:0]   cnt_q, cnt_d, load_q;
    logic           per_q, slow_q, irq_q, irq_d;
    logic           tick_sel, at_zero;
    logic           unused_wdata;

    assign unused_wdata = ^wdata;
    assign tick_sel     = slow_q ? tick_slow : tick_fast;
    assign at_zero      = (cnt_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    // transitions: start / stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT:  if (wr_ctrl && wdata[BIT_EN])  state_d = CH_COUNT;
            CH_COUNT: if (wr_ctrl && !wdata[BIT_EN]) state_d = CH_HALT;
            default:  state_d = CH_HALT;
        endcase
    end

    // datapath outputs of the state machine
    always_comb begin
        cnt_d = cnt_q;
        irq_d = irq_q & ~wr_clear;
        unique case (state_q)
            CH_HALT: begin
                if (state_d == CH_COUNT) cnt_d = load_q;
            end
            CH_COUNT: begin
                if (!wr_ctrl && tick_sel) begin
                    if (at_zero) begin
                        cnt_d = per_q ? load_q : '1;
                        irq_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q - W'(1);
                    end
                end
            end
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            load_q <= '0;
            per_q  <= 1'b0;
            slow_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= irq_d;
            if (wr_load) load_q <= wdata[W-1:0];
            if (wr_ctrl) begin
                per_q  <= wdata[BIT_PERIODIC];
                slow_q <= wdata[BIT_SLOW];
            end
        end
    end

    assign rd_count = 32'(cnt_q);
    assign rd_load  = 32'(load_q);
    assign rd_ctrl  = (32'(state_q == CH_COUNT) << BIT_EN)
                    | (32'(per_q) << BIT_PERIODIC)
                    | (32'(slow_q) << BIT_SLOW);
    assign irq      = irq_q;

    // R7: underflow raises the pending flag on the same edge
    p_underflow_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && !wr_ctrl && tick_sel && at_zero) |=> irq);
    // R5: periodic underflow reloads the load value
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && !wr_ctrl && tick_sel && at_zero && per_q && !wr_load)
        |=> (rd_count == rd_load));
    // R6: free-running underflow wraps to all ones
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && !wr_ctrl && tick_sel && at_zero && !per_q)
        |=> (cnt_q == '1));
    // R9: a halted channel holds its count
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT && !wr_ctrl) |=> $stable(cnt_q));
    // R8: clear without a concurrent underflow empties the flag
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && !(state_q == CH_COUNT && !wr_ctrl && tick_sel && at_zero))
        |=> !irq);
endmodule

// File: rtl/stamp_chan.sv
module stamp_chan
    import tmr_pkg::*;
#(
    parameter int W = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_fast,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [31:0] rd_lo,
    output logic [31:0] rd_hi
);
    ch_state_t    state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         unused_wdata;

    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT:  if (wr_hi && wdata[BIT_STAMP_EN])  state_d = CH_COUNT;
            CH_COUNT: if (wr_hi && !wdata[BIT_STAMP_EN]) state_d = CH_HALT;
            default:  state_d = CH_HALT;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (state_q)
            CH_HALT:  cnt_d = '0;
            CH_COUNT: begin
                if (state_d == CH_HALT) cnt_d = '0;
                else if (tick_fast)     cnt_d = cnt_q + W'(1);
            end
            default:  cnt_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rd_lo = cnt_q[31:0];
    assign rd_hi = 32'(cnt_q[W-1:32]) | (32'(state_q == CH_COUNT) << BIT_STAMP_EN);

    // R10: an enabled counter advances by one per fast tick
    p_stamp_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && tick_fast && !wr_hi) |=> (cnt_q == $past(cnt_q) + W'(1)));
    // R10: a disabled counter sits at zero
    p_stamp_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT) |-> (cnt_q == '0));
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
    import tmr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int STAMP_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [2:0]        irq
);
    localparam logic [1:0] STAMP_IDX = 2'd3;

    logic [1:0]  ch_idx;
    reg_sel_t    reg_sel;
    logic        addr_ok;
    logic [31:0] rd_cnt  [DOWN_CH_N];
    logic [31:0] rd_ld   [DOWN_CH_N];
    logic [31:0] rd_ct   [DOWN_CH_N];
    logic [31:0] st_lo, st_hi;

    assign ch_idx  = bus_addr[5:4];
    assign reg_sel = reg_sel_t'(bus_addr[3:2]);
    assign addr_ok = (bus_addr[ADDR_W-1:6] == '0) && (bus_addr[1:0] == 2'b00);

    for (genvar c = 0; c < DOWN_CH_N; c++) begin : g_down
        localparam int CW = (c == DOWN_CH_N - 1) ? WIDE_W : NARROW_W;
        logic hit;
        assign hit = bus_wr && addr_ok && (ch_idx == 2'(c));
        down_chan #(.W(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_slow(tick_slow),
            .tick_fast(tick_fast),
            .wr_load  (hit && reg_sel == REG_LOAD),
            .wr_ctrl  (hit && reg_sel == REG_CTRL),
            .wr_clear (hit && reg_sel == REG_CLEAR),
            .wdata    (bus_wdata),
            .rd_count (rd_cnt[c]),
            .rd_load  (rd_ld[c]),
            .rd_ctrl  (rd_ct[c]),
            .irq      (irq[c])
        );
    end

    stamp_chan #(.W(STAMP_W)) u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_fast(tick_fast),
        .wr_hi    (bus_wr && addr_ok && ch_idx == STAMP_IDX && reg_sel == REG_COUNT),
        .wdata    (bus_wdata),
        .rd_lo    (st_lo),
        .rd_hi    (st_hi)
    );

    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            if (ch_idx == STAMP_IDX) begin
                if (reg_sel == REG_LOAD)  bus_rdata = st_lo;
                if (reg_sel == REG_COUNT) bus_rdata = st_hi;
            end else begin
                for (int c = 0; c < DOWN_CH_N; c++) begin
                    if (ch_idx == 2'(c)) begin
                        unique case (reg_sel)
                            REG_LOAD:  bus_rdata = rd_ld[c];
                            REG_COUNT: bus_rdata = rd_cnt[c];
                            REG_CTRL:  bus_rdata = rd_ct[c];
                            REG_CLEAR: bus_rdata = '0;
                            default:   bus_rdata = '0;
                        endcase
                    end
                end
            end
        end
    end

    // R1: no pending interrupt straight after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq == 3'b000));
endmodule

// File: tb/tick_timer_unit_test.sv
`timescale 1ns/100ps
module tick_timer_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_slow = 1'b0;
    logic        tick_fast = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errs   = 0;

    logic [31:0] m_cnt  [3];
    logic [31:0] m_load [3];
    logic        m_en   [3];
    logic        m_per  [3];
    logic        m_slow [3];
    logic        m_irq  [3];
    logic [39:0] m_st;
    logic        m_sten;

    tick_timer_unit uut (
        .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] wmask(input int c);
        return (c < 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] ctrl_val(input int c);
        return (32'(m_en[c]) << 7) | (32'(m_per[c]) << 6) | (32'(m_slow[c]) << 3);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic model_apply(input logic w, input logic [7:0] a, input logic [31:0] d,
                               input logic s, input logic f);
        for (int c = 0; c < 3; c++) begin
            logic hit_ld, hit_ct, hit_cl, uf;
            hit_ld = w && a == 8'(16 * c);
            hit_ct = w && a == 8'(16 * c + 8);
            hit_cl = w && a == 8'(16 * c + 12);
            uf = 1'b0;
            if (hit_ct) begin
                m_per[c]  = d[6];
                m_slow[c] = d[3];
                if (d[7] && !m_en[c]) begin
                    m_en[c]  = 1'b1;
                    m_cnt[c] = m_load[c];
                end else if (!d[7]) begin
                    m_en[c] = 1'b0;
                end
            end else if (m_en[c] && (m_slow[c] ? s : f)) begin
                if (m_cnt[c] == 0) begin
                    m_cnt[c] = m_per[c] ? m_load[c] : wmask(c);
                    uf = 1'b1;
                end else begin
                    m_cnt[c] = m_cnt[c] - 1;
                end
            end
            if (uf) m_irq[c] = 1'b1;
            else if (hit_cl) m_irq[c] = 1'b0;
            if (hit_ld) m_load[c] = d & wmask(c);
        end
        if (w && a == 8'h34) begin
            if (!d[8]) m_st = '0;
            else if (m_sten && f) m_st = m_st + 40'd1;
            m_sten = d[8];
        end else if (m_sten && f) begin
            m_st = m_st + 40'd1;
        end
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic s, input logic f);
        bus_wr = w; bus_addr = a; bus_wdata = d; tick_slow = s; tick_fast = f;
        model_apply(w, a, d, s, f);
        @(negedge clk);
        bus_wr = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic tk(input logic s, input logic f);
        step(1'b0, 8'h00, 32'h0, s, f);
    endtask

    task automatic check_all();
        logic [31:0] v;
        for (int c = 0; c < 3; c++) begin
            rd(8'(16 * c + 4), v); chk("R3 count", v, m_cnt[c]);
            rd(8'(16 * c), v);     chk("R2 load", v, m_load[c]);
            rd(8'(16 * c + 8), v); chk("R12 ctrl", v, ctrl_val(c));
            chk("R7 irq", 32'(irq[c]), 32'(m_irq[c]));
        end
        rd(8'h30, v); chk("R11 stamp low", v, m_st[31:0]);
        rd(8'h34, v); chk("R11 stamp high", v, 32'(m_st[39:32]) | (32'(m_sten) << 8));
    endtask

    initial begin
        #(20.0 * 150000);
        errs++; checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        for (int c = 0; c < 3; c++) begin
            m_cnt[c] = 0; m_load[c] = 0; m_en[c] = 0;
            m_per[c] = 0; m_slow[c] = 0; m_irq[c] = 0;
        end
        m_st = '0; m_sten = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_all();
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // R2 width of the load registers
        wr(8'h00, 32'h0001_2345);
        rd(8'h00, v); chk("R2 narrow load", v, 32'h0000_2345);
        wr(8'h20, 32'hDEAD_BEEF);
        rd(8'h20, v); chk("R2 wide load", v, 32'hDEAD_BEEF);

        // R3 / R9 programming sequence on channel 0, periodic, slow tick
        wr(8'h00, 32'd3);
        wr(8'h08, 32'h48);
        rd(8'h08, v); chk("R12 ctrl readback", v, 32'h48);
        rd(8'h04, v); chk("R9 halted count", v, 32'h0);
        wr(8'h08, 32'hC8);
        rd(8'h04, v); chk("R3 start loads", v, 32'd3);

        // R4 fast tick ignored when slow selected
        tk(1'b0, 1'b1);
        rd(8'h04, v); chk("R4 other tick ignored", v, 32'd3);

        // R5 period of N ticks for load N-1
        repeat (3) tk(1'b1, 1'b0);
        rd(8'h04, v); chk("R5 count at zero", v, 32'd0);
        chk("R7 no irq before underflow", 32'(irq[0]), 32'h0);
        tk(1'b1, 1'b0);
        rd(8'h04, v); chk("R5 reload", v, 32'd3);
        chk("R7 irq at underflow", 32'(irq[0]), 32'h1);

        // R8 clear, then clear concurrent with underflow
        wr(8'h0C, 32'h0);
        chk("R8 clear drops flag", 32'(irq[0]), 32'h0);
        repeat (3) tk(1'b1, 1'b0);
        step(1'b1, 8'h0C, 32'h0, 1'b1, 1'b0);
        chk("R8 underflow wins", 32'(irq[0]), 32'h1);
        rd(8'h04, v); chk("R5 reload again", v, 32'd3);
        wr(8'h0C, 32'h0);

        // R6 free-running wrap, narrow and wide
        wr(8'h10, 32'd1);
        wr(8'h18, 32'h80);
        tk(1'b0, 1'b1);
        tk(1'b0, 1'b1);
        rd(8'h14, v); chk("R6 narrow wrap", v, 32'h0000_FFFF);
        chk("R7 irq ch1", 32'(irq[1]), 32'h1);
        wr(8'h20, 32'h0);
        wr(8'h28, 32'h88);
        tk(1'b1, 1'b0);
        rd(8'h24, v); chk("R6 wide wrap", v, 32'hFFFF_FFFF);

        // R9 halt holds, re-enable reloads
        wr(8'h18, 32'h00);
        tk(1'b0, 1'b1);
        rd(8'h14, v); chk("R9 hold", v, 32'h0000_FFFF);
        wr(8'h18, 32'h80);
        rd(8'h14, v); chk("R9 reload on enable", v, 32'd1);

        // R10 / R11 timestamp channel
        wr(8'h34, 32'h100);
        rd(8'h34, v); chk("R11 enable flag", v, 32'h100);
        repeat (3) tk(1'b0, 1'b1);
        rd(8'h30, v); chk("R10 stamp counts", v, 32'd3);
        wr(8'h34, 32'h0);
        rd(8'h30, v); chk("R10 stamp zeroed", v, 32'd0);
        rd(8'h34, v); chk("R11 disabled high", v, 32'd0);

        check_all();

        // random phase against the bench model
        for (int i = 0; i < 600; i++) begin
            int r;
            int c;
            r = $urandom % 8;
            c = $urandom % 3;
            case (r)
                4: step(1'b1, 8'(16 * c + 8),
                        (32'($urandom % 2) << 7) | (32'($urandom % 2) << 6) | (32'($urandom % 2) << 3),
                        1'b0, 1'b0);
                5: step(1'b1, 8'(16 * c), $urandom % 6, 1'($urandom), 1'($urandom));
                6: step(1'b1, 8'(16 * c + 12), $urandom, 1'($urandom), 1'($urandom));
                7: step(1'b1, 8'h34, 32'($urandom % 2) << 8, 1'b0, 1'($urandom));
                default: step(1'b0, 8'h00, 32'h0, 1'($urandom), 1'($urandom));
            endcase
            check_all();
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule